// File: doc/BRIEF.md
# Stereo Peak Limiter with Zero-Cross Gain Commit

This block scales a stereo stream of signed 16-bit PCM samples by one gain and lowers that gain whenever either channel's scaled output gets too loud. A sample strobe carries one left and one right sample. The scaled pair comes out one clock later with its own strobe. The gain is a 6-bit code in 0.375 dB steps. Code 47 is unity gain. Code 63 is the reset value, about +6 dB. Code 0 is the floor.

When the limiter is enabled and either output magnitude reaches the selected threshold, the shared target code drops by the selected number of steps on that strobe. The drop repeats on every strobe that still reaches the threshold. The channels do not adopt a new target together. Each channel keeps its own applied code and copies the target only at a moment that hides the step:

- its own zero crossing;
- a timeout counted in sample strobes;
- a sample whose scaled value clips.

With zero-cross handling bypassed, both channels copy the target at once and the step is always one code.

Top module: `alc_limiter`

## Requirements
- R1: Reset gives `gain_code` = 63, `res_stb` = 0 and both result samples 0. Both channels' applied codes start at 63.
- R2: For each `smp_stb`, `res_stb` pulses one clock later. Each result sample is computed from its input x and that channel's applied code c as floor(x*G(c)/32768), saturated to the range -32768..32767. G(c) = round(32768*10^(0.375*(c-47)/20)). Without a strobe, the result samples hold their value.
- R3: On a strobe with the limiter enabled, attenuation starts when either channel's saturated result magnitude is at or above the threshold for `lim_thr_sel`. The thresholds for codes 0, 1, 2 and 3 are 24573, 20438, 16423 and 12315. A magnitude one below the threshold causes no attenuation.
- R4: With zero-cross handling active, each attenuation lowers `gain_code` by `lim_step_sel`+1 codes. The code stops at 0 and never wraps.
- R5: With `zc_bypass` = 1, each attenuation lowers `gain_code` by exactly 1, whatever `lim_step_sel` holds. Both channels apply the new code from the next strobe on.
- R6: A channel whose applied code differs from the target copies the target on a strobe where its input is zero or its sign differs from its previous input. The other channel is not affected.
- R7: A pending channel with no zero crossing copies the target on its (128 << `zc_tmo_sel`)-th consecutive pending strobe.
- R8: A pending channel whose scaled sample saturates on a strobe copies the target on that strobe.
- R9: Attenuation happens on every strobe that reaches the threshold. The gain stays fixed on strobes below it.
- R10: With `lim_en` = 0, `gain_code` does not change and no channel copies the target. Each strobe clears the timeout counters, and scaling continues with the held applied codes.
- R11: `gain_code` changes only at a clock edge where `smp_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | Input sample pair valid |
| smp_l | input | 16 | Left input sample, signed |
| smp_r | input | 16 | Right input sample, signed |
| lim_en | input | 1 | Limiter enable |
| lim_thr_sel | input | 2 | Detection threshold select |
| lim_step_sel | input | 2 | Steps per event minus one |
| zc_bypass | input | 1 | Apply gain at once, single step |
| zc_tmo_sel | input | 2 | Zero-cross timeout select |
| res_stb | output | 1 | Result sample pair valid |
| res_l | output | 16 | Left scaled sample, signed |
| res_r | output | 16 | Right scaled sample, signed |
| gain_code | output | 6 | Current target gain code |

## Verification
A channel's commit and a new limiter decrement can land on the same strobe. The commit must then take the freshly lowered target, not the previous one. The bench provokes this by holding the left channel loud and steady, so it never crosses zero and triggers attenuation on every strobe, while the right channel flips sign on every strobe. Each right result is then judged against the gain code read just before its strobe. The left result must stay at the reset scale until the timeout or a clipping sample forces the commit.

// File: rtl/alc_lim_pkg.sv
package alc_lim_pkg;

   localparam int NCH = 2;

   // Detection levels as magnitudes of a 16-bit full-scale sample.
   function automatic int unsigned thr_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 24573;
         2'd1:    return 20438;
         2'd2:    return 16423;
         default: return 12315;
      endcase
   endfunction

   // Linear multiplier for a gain code, 0.375 dB per code, 'unity' is 0 dB.
   function automatic int gain_lin(input int code, input int unity, input int frac);
      real db;
      real lin;
      db  = 0.375 * real'(code - unity);
      lin = (2.0 ** frac) * (10.0 ** (db / 20.0));
      return $rtoi(lin + 0.5);
   endfunction

endpackage

// File: rtl/alc_gain_lut.sv
module alc_gain_lut #(
   parameter int CODE_W     = 6,
   parameter int LIN_W      = 18,
   parameter int UNITY_CODE = 47,
   parameter int FRAC_W     = 15
) (
   input  logic [CODE_W-1:0] code,
   output logic [LIN_W-1:0]  lin
);
   localparam int NCODE = 1 << CODE_W;

   logic [LIN_W-1:0] tab [NCODE];

   for (genvar i = 0; i < NCODE; i++) begin : g_ent
      localparam int LV = alc_lim_pkg::gain_lin(i, UNITY_CODE, FRAC_W);
      if (LV >= (1 << LIN_W)) begin : g_bad
         $error("gain table entry exceeds LIN_W");
      end
      assign tab[i] = LIN_W'(LV);
   end

   assign lin = tab[code];
endmodule

// File: rtl/alc_chan.sv
module alc_chan #(
   parameter int SAMP_W     = 16,
   parameter int CODE_W     = 6,
   parameter int LIN_W      = 18,
   parameter int FRAC_W     = 15,
   parameter int UNITY_CODE = 47,
   parameter int RST_CODE   = 63,
   parameter int TMO_BASE   = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     strobe,
   input  logic                     en,
   input  logic                     zc_off,
   input  logic [1:0]               tmo_sel,
   input  logic signed [SAMP_W-1:0] x,
   input  logic [CODE_W-1:0]        tgt_nxt,
   output logic signed [SAMP_W-1:0] y_now,
   output logic signed [SAMP_W-1:0] y_q
);
   localparam int PW    = SAMP_W + LIN_W + 1;
   localparam int CNT_W = $clog2(TMO_BASE) + 3;
   localparam logic signed [SAMP_W-1:0] YMAX = {1'b0, {(SAMP_W-1){1'b1}}};
   localparam logic signed [SAMP_W-1:0] YMIN = {1'b1, {(SAMP_W-1){1'b0}}};

   logic [CODE_W-1:0]        app_q, app_d;
   logic [CNT_W-1:0]         cnt_q, cnt_d, lim;
   logic [CNT_W:0]           span;
   logic                     neg_q;
   logic [LIN_W-1:0]         lin;
   logic signed [PW-1:0]     xe, ge, prod, sh;
   logic [PW-SAMP_W:0]       hi;
   logic                     clip, zc, pend;

   alc_gain_lut #(
      .CODE_W(CODE_W), .LIN_W(LIN_W), .UNITY_CODE(UNITY_CODE), .FRAC_W(FRAC_W)
   ) u_lut (
      .code(app_q),
      .lin (lin)
   );

   always_comb begin
      xe    = PW'(x);
      ge    = PW'({1'b0, lin});
      prod  = xe * ge;
      sh    = prod >>> FRAC_W;
      hi    = sh[PW-1:SAMP_W-1];
      clip  = !((&hi) || (~|hi));
      y_now = clip ? (sh[PW-1] ? YMIN : YMAX) : sh[SAMP_W-1:0];
   end

   assign zc   = (x == '0) || (x[SAMP_W-1] != neg_q);
   assign pend = (app_q != tgt_nxt);
   assign span = (CNT_W+1)'(TMO_BASE) << tmo_sel;
   assign lim  = CNT_W'(span - 1'b1);

   always_comb begin
      app_d = app_q;
      cnt_d = cnt_q;
      if (strobe) begin
         if (!en) begin
            cnt_d = '0;
         end else if (pend) begin
            if (zc_off || clip || zc || (cnt_q == lim)) begin
               app_d = tgt_nxt;
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end else begin
            cnt_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         app_q <= CODE_W'(RST_CODE);
         cnt_q <= '0;
         neg_q <= 1'b0;
         y_q   <= '0;
      end else begin
         app_q <= app_d;
         cnt_q <= cnt_d;
         if (strobe) begin
            neg_q <= x[SAMP_W-1];
            y_q   <= y_now;
         end
      end
   end
endmodule

// File: rtl/alc_ctrl.sv
module alc_ctrl #(
   parameter int SAMP_W   = 16,
   parameter int CODE_W   = 6,
   parameter int RST_CODE = 63
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     strobe,
   input  logic                     en,
   input  logic [1:0]               thr_sel,
   input  logic [1:0]               step_sel,
   input  logic                     zc_off,
   input  logic signed [SAMP_W-1:0] y_l,
   input  logic signed [SAMP_W-1:0] y_r,
   output logic [CODE_W-1:0]        gain_q,
   output logic [CODE_W-1:0]        tgt_nxt
);
   logic signed [SAMP_W:0] ye_l, ye_r;
   logic [SAMP_W:0]        mag_l, mag_r, thr;
   logic [CODE_W-1:0]      step;
   logic                   det;

   always_comb begin
      ye_l  = (SAMP_W+1)'(y_l);
      ye_r  = (SAMP_W+1)'(y_r);
      mag_l = ye_l[SAMP_W] ? unsigned'(-ye_l) : unsigned'(ye_l);
      mag_r = ye_r[SAMP_W] ? unsigned'(-ye_r) : unsigned'(ye_r);
      thr   = (SAMP_W+1)'(alc_lim_pkg::thr_level(thr_sel));
      det   = strobe && en && ((mag_l >= thr) || (mag_r >= thr));
      step  = zc_off ? CODE_W'(1) : CODE_W'(step_sel) + CODE_W'(1);
      if (!det)              tgt_nxt = gain_q;
      else if (gain_q > step) tgt_nxt = gain_q - step;
      else                   tgt_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gain_q <= CODE_W'(RST_CODE);
      else        gain_q <= tgt_nxt;
   end
endmodule

// File: rtl/alc_limiter.sv
module alc_limiter #(
   parameter int SAMP_W     = 16,
   parameter int CODE_W     = 6,
   parameter int FRAC_W     = 15,
   parameter int UNITY_CODE = 47,
   parameter int RST_CODE   = 63,
   parameter int TMO_BASE   = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_stb,
   input  logic signed [SAMP_W-1:0] smp_l,
   input  logic signed [SAMP_W-1:0] smp_r,
   input  logic                     lim_en,
   input  logic [1:0]               lim_thr_sel,
   input  logic [1:0]               lim_step_sel,
   input  logic                     zc_bypass,
   input  logic [1:0]               zc_tmo_sel,
   output logic                     res_stb,
   output logic signed [SAMP_W-1:0] res_l,
   output logic signed [SAMP_W-1:0] res_r,
   output logic [CODE_W-1:0]        gain_code
);
   localparam int NCH   = alc_lim_pkg::NCH;
   localparam int LIN_W = FRAC_W + 3;

   if (SAMP_W != 16) begin : g_bad_w
      $error("threshold constants assume 16-bit samples");
   end
   if (CODE_W < 3) begin : g_bad_c
      $error("CODE_W must hold a four-code step");
   end
   if (RST_CODE >= (1 << CODE_W) || UNITY_CODE >= (1 << CODE_W)) begin : g_bad_r
      $error("reset or unity code out of range");
   end
   if (TMO_BASE < 2 || (TMO_BASE & (TMO_BASE - 1)) != 0) begin : g_bad_t
      $error("TMO_BASE must be a power of two");
   end

   logic signed [SAMP_W-1:0] xin  [NCH];
   logic signed [SAMP_W-1:0] ynow [NCH];
   logic signed [SAMP_W-1:0] yreg [NCH];
   logic [CODE_W-1:0]        tgt_nxt;

   assign xin[0] = smp_l;
   assign xin[1] = smp_r;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      alc_chan #(
         .SAMP_W(SAMP_W), .CODE_W(CODE_W), .LIN_W(LIN_W), .FRAC_W(FRAC_W),
         .UNITY_CODE(UNITY_CODE), .RST_CODE(RST_CODE), .TMO_BASE(TMO_BASE)
      ) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .strobe (smp_stb),
         .en     (lim_en),
         .zc_off (zc_bypass),
         .tmo_sel(zc_tmo_sel),
         .x      (xin[c]),
         .tgt_nxt(tgt_nxt),
         .y_now  (ynow[c]),
         .y_q    (yreg[c])
      );
   end

   alc_ctrl #(
      .SAMP_W(SAMP_W), .CODE_W(CODE_W), .RST_CODE(RST_CODE)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (smp_stb),
      .en      (lim_en),
      .thr_sel (lim_thr_sel),
      .step_sel(lim_step_sel),
      .zc_off  (zc_bypass),
      .y_l     (ynow[0]),
      .y_r     (ynow[1]),
      .gain_q  (gain_code),
      .tgt_nxt (tgt_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_stb <= 1'b0;
      else        res_stb <= smp_stb;
   end

   assign res_l = yreg[0];
   assign res_r = yreg[1];
endmodule

// File: rtl/alc_limiter_chk.sv
module alc_limiter_chk #(
   parameter int CODE_W   = 6,
   parameter int RST_CODE = 63
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_stb,
   input logic              lim_en,
   input logic              zc_bypass,
   input logic              res_stb,
   input logic [CODE_W-1:0] gain_code
);
   // R1
   reset_val_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (gain_code == CODE_W'(RST_CODE)) && !res_stb);

   // R11
   gain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(gain_code));

   // R10
   gain_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lim_en |=> $stable(gain_code));

   // R4
   gain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> (gain_code <= $past(gain_code)) &&
                  (($past(gain_code) - gain_code) <= CODE_W'(4)));

   // R5
   bypass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && zc_bypass) |=> (gain_code <= $past(gain_code)) &&
                                 (($past(gain_code) - gain_code) <= CODE_W'(1)));

   // R2
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> res_stb);

   // R2
   res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> !res_stb);
endmodule

bind alc_limiter alc_limiter_chk #(.CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_stb  (smp_stb),
   .lim_en   (lim_en),
   .zc_bypass(zc_bypass),
   .res_stb  (res_stb),
   .gain_code(gain_code)
);

// File: tb/alc_limiter_test.sv
module alc_limiter_test;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_stb = 1'b0;
   logic signed [15:0] smp_l = '0;
   logic signed [15:0] smp_r = '0;
   logic               lim_en = 1'b0;
   logic [1:0]         lim_thr_sel = '0;
   logic [1:0]         lim_step_sel = '0;
   logic               zc_bypass = 1'b0;
   logic [1:0]         zc_tmo_sel = '0;
   logic               res_stb;
   logic signed [15:0] res_l, res_r;
   logic [5:0]         gain_code;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 0;
   string cur_req  = "R1";

   // reference model state
   int m_gain;
   int m_app [2];
   int m_cnt [2];
   bit m_neg [2];
   int m_out [2];
   bit m_vld;

   alc_limiter uut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
      .lim_en(lim_en), .lim_thr_sel(lim_thr_sel), .lim_step_sel(lim_step_sel),
      .zc_bypass(zc_bypass), .zc_tmo_sel(zc_tmo_sel), .res_stb(res_stb),
      .res_l(res_l), .res_r(res_r), .gain_code(gain_code)
   );

   always #2 clk = ~clk;

   function automatic int lin(int c);
      real v;
      v = 32768.0 * (10.0 ** ((0.375 * real'(c - 47)) / 20.0));
      return $rtoi(v + 0.5);
   endfunction

   function automatic int raw(int x, int c);
      longint p;
      p = longint'(x) * longint'(lin(c));
      p = p >>> 15;
      return int'(p);
   endfunction

   function automatic int sc(int x, int c);
      int y;
      y = raw(x, c);
      if (y > 32767) y = 32767;
      if (y < -32768) y = -32768;
      return y;
   endfunction

   function automatic int thr(int s);
      case (s)
         0: return 24573;
         1: return 20438;
         2: return 16423;
         default: return 12315;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_init();
      m_gain = 63;
      m_vld  = 0;
      for (int c = 0; c < 2; c++) begin
         m_app[c] = 63; m_cnt[c] = 0; m_neg[c] = 0; m_out[c] = 0;
      end
   endtask

   task automatic model_step(bit v, int l, int r);
      int x [2];
      int y [2];
      bit clp [2];
      int tgt, stp, lim, mg;
      bit det, zc;
      if (!v) begin
         m_vld = 0;
         return;
      end
      x[0] = l; x[1] = r;
      det = 0;
      for (int c = 0; c < 2; c++) begin
         y[c]   = sc(x[c], m_app[c]);
         clp[c] = (y[c] != raw(x[c], m_app[c]));
         mg     = (y[c] < 0) ? -y[c] : y[c];
         if (mg >= thr(lim_thr_sel)) det = 1;
      end
      tgt = m_gain;
      if (lim_en && det) begin
         stp = zc_bypass ? 1 : int'(lim_step_sel) + 1;
         tgt = (m_gain > stp) ? m_gain - stp : 0;
      end
      lim = (128 << zc_tmo_sel) - 1;
      for (int c = 0; c < 2; c++) begin
         zc = (x[c] == 0) || ((x[c] < 0) != m_neg[c]);
         if (!lim_en) m_cnt[c] = 0;
         else if (m_app[c] != tgt) begin
            if (zc_bypass || clp[c] || zc || m_cnt[c] == lim) begin
               m_app[c] = tgt; m_cnt[c] = 0;
            end else m_cnt[c]++;
         end else m_cnt[c] = 0;
         m_neg[c] = (x[c] < 0);
         m_out[c] = y[c];
      end
      m_gain = tgt;
      m_vld  = 1;
   endtask

   task automatic compare();
      chk(cur_req, int'(gain_code), m_gain);
      chk("R2", int'(res_stb), int'(m_vld));
      if (m_vld) begin
         chk(cur_req, int'(res_l), m_out[0]);
         chk(cur_req, int'(res_r), m_out[1]);
      end
   endtask

   task automatic cyc(bit v, int l, int r);
      @(negedge clk);
      smp_stb = v; smp_l = 16'(l); smp_r = 16'(r);
      model_step(v, l, r);
      @(posedge clk);
      #1;
      compare();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; smp_stb = 0;
      model_init();
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int g, x, sg;
      model_init();
      do_reset();
      @(posedge clk); #1;
      // R1 reset state
      chk("R1", int'(gain_code), 63);
      chk("R1", int'(res_stb), 0);
      chk("R1", int'(res_l), 0);
      chk("R1", int'(res_r), 0);

      // R2 scaling with limiter off
      cur_req = "R2";
      cyc(1, 1000, -1000);
      chk("R2", int'(res_l), sc(1000, 63));
      chk("R2", int'(res_r), sc(-1000, 63));
      cyc(0, 0, 0);
      chk("R2", int'(res_stb), 0);
      chk("R2", int'(res_l), sc(1000, 63));
      cyc(1, 12345, -20000);
      chk("R10", int'(gain_code), 63);
      cyc(1, 0, 0);

      // R5 bypass, single step, R11 gaps
      cur_req = "R5";
      lim_en = 1; zc_bypass = 1; lim_thr_sel = 0; lim_step_sel = 3;
      cyc(1, 20000, 0);
      chk("R5", int'(gain_code), 62);
      cur_req = "R11";
      for (int k = 0; k < 30; k++) begin
         cyc(0, 0, 0);
         cyc(1, 20000, 0);
      end
      cur_req = "R9";
      chk("R9", int'(gain_code), 51);
      for (int k = 0; k < 10; k++) cyc(1, 20000, 0);
      chk("R9", int'(gain_code), 51);

      // R4 / R6 / R7: left pending, right crossing each strobe
      do_reset();
      lim_en = 1; zc_bypass = 0; lim_thr_sel = 0; lim_step_sel = 3; zc_tmo_sel = 0;
      cur_req = "R6";
      for (int k = 1; k <= 140; k++) begin
         g = int'(gain_code);
         cyc(1, 15000, (k % 2 == 1) ? -100 : 100);
         chk("R6", int'(res_r), sc((k % 2 == 1) ? -100 : 100, g));
         if (k == 20) chk("R4", int'(gain_code), 0);
         if (k == 128) chk("R7", int'(res_l), sc(15000, 63));
         if (k == 129) chk("R7", int'(res_l), sc(15000, 0));
      end

      // R8 clipping commits at once
      do_reset();
      lim_en = 1; zc_bypass = 0; lim_thr_sel = 3; lim_step_sel = 0; zc_tmo_sel = 3;
      cur_req = "R8";
      cyc(1, 100, 50);
      chk("R8", int'(gain_code), 63);
      cyc(1, 20000, 50);
      chk("R8", int'(gain_code), 62);
      cyc(1, 20000, 50);
      chk("R8", int'(res_l), sc(20000, 62));
      cyc(1, 8000, 50);
      chk("R8", int'(res_l), sc(8000, 61));
      chk("R6", int'(res_r), sc(50, 63));

      // R10 disable freezes gain
      cur_req = "R10";
      g = int'(gain_code);
      lim_en = 0;
      for (int k = 0; k < 5; k++) cyc(1, 20000, -20000);
      chk("R10", int'(gain_code), g);
      lim_en = 1;
      for (int k = 0; k < 5; k++) cyc(1, 3000, 40);

      // R3 threshold edges for every select
      cur_req = "R3";
      for (int s = 0; s < 4; s++) begin
         do_reset();
         lim_en = 1; zc_bypass = 1; lim_thr_sel = 2'(s);
         sg = (s % 2 == 0) ? 1 : -1;
         x = 1;
         while (((sc(sg * x, 63) < 0) ? -sc(sg * x, 63) : sc(sg * x, 63)) < thr(s)) x++;
         if (s % 2 == 0) cyc(1, sg * (x - 1), 0);
         else            cyc(1, 0, sg * (x - 1));
         chk("R3", int'(gain_code), 63);
         if (s % 2 == 0) cyc(1, sg * x, 0);
         else            cyc(1, 0, sg * x);
         chk("R3", int'(gain_code), 62);
      end

      // R7 longest timeout
      do_reset();
      lim_en = 1; zc_bypass = 0; lim_thr_sel = 3; lim_step_sel = 0; zc_tmo_sel = 3;
      cur_req = "R7";
      for (int k = 1; k <= 1030; k++) begin
         cyc(1, 10000, 0);
         if (k == 1024) chk("R7", int'(res_l), sc(10000, 63));
         if (k == 1025) chk("R7", int'(res_l), sc(10000, 0));
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end
endmodule